// File: doc/BRIEF.md
# Split-Half Signed Wide Multiplier

This block forms the exact two's-complement product of two signed operands (36 bits each by default) as a full double-width result (72 bits). Each operand is cut into an upper half and a lower half. The upper half is taken as signed and the lower half as unsigned. The halves are multiplied with narrow multipliers that match the 18x18 hard units found in FPGA fabric, and the partial products are then shifted and summed. A plain wide signed multiply would occupy nine such units. This block needs four in the schoolbook arrangement and three in the Karatsuba arrangement, selected by a parameter.

The pipeline has two register stages. The first holds the partial products and the second holds the recombined sum. A valid flag travels beside the data, so a result appears exactly two clock edges after its operands were accepted. A new operand pair may be presented on every cycle.

Top module: `wide_smul`

## Requirements
- R1: For every pair of signed operands, `prod_out` equals the exact signed product `a_in * b_in`, sign-extended to the full 2*W width.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after the second rising edge that follows, and the matching product is on `prod_out`.
- R3: When `in_valid` is low at a rising edge, `out_valid` is low two edges later.
- R4: Operand pairs presented on consecutive cycles produce their results on consecutive cycles, in the same order.
- R5: Most-negative times most-negative (-2^35 * -2^35) gives +2^70.
- R6: Most-negative times -1 gives +2^35, with no wrap.
- R7: A zero operand gives a zero product, whatever the sign of the other operand.
- R8: While `out_valid` is low, `prod_out` keeps the last product that was delivered.
- R9: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `prod_out` is 0.
- R10: The four-multiplier setting (`ARCH = ARCH_FOUR`) and the three-multiplier setting (`ARCH = ARCH_THREE`) give identical outputs, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `a_in`/`b_in` as a pair to multiply |
| a_in | input | W (36) | Signed multiplicand |
| b_in | input | W (36) | Signed multiplier |
| out_valid | output | 1 | Marks `prod_out` as a fresh result |
| prod_out | output | 2*W (72) | Signed product, registered |

## Verification
The assertions assume that `in_valid` is a known 0 or 1 at every edge after reset. They also assume that the operands are defined whenever `in_valid` is high, because the product check looks back two cycles to the sampled inputs. The bench drives every input from time zero and changes them only on falling edges. It keeps `in_valid` low whenever it is not presenting a pair, and it leaves the operands at defined values during gaps. Both architecture settings are instantiated side by side on the same stimulus.

// File: rtl/wide_smul_pkg.sv
package wide_smul_pkg;
  // Selects how many narrow multipliers build the product
  typedef enum logic [0:0] {
    ARCH_FOUR  = 1'b0,  // schoolbook: hh, hl, lh, ll
    ARCH_THREE = 1'b1   // Karatsuba: hh, ll, (aH+aL)*(bH+bL)
  } smul_arch_e;
endpackage

// File: rtl/smul_half_split.sv
module smul_half_split #(
  parameter int W = 36,
  localparam int H = W / 2
) (
  input  logic signed [W-1:0] op,
  output logic signed [H-1:0] hi,
  output logic        [H-1:0] lo
);
  // Upper half carries the sign, lower half is a plain magnitude
  assign hi = op[W-1:H];
  assign lo = op[H-1:0];
endmodule

// File: rtl/smul_partial_stage.sv
module smul_partial_stage
  import wide_smul_pkg::*;
#(
  parameter int         W    = 36,
  parameter smul_arch_e ARCH = ARCH_THREE,
  localparam int H  = W / 2,
  localparam int PW = 2 * H,       // width of a half-by-half product
  localparam int CW = 2 * H + 1,   // signed-by-unsigned product
  localparam int SW = H + 2,       // signed half sum, no truncation
  localparam int XW = 2 * H + 4    // middle term register width
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [H-1:0]  a_hi,
  input  logic        [H-1:0]  a_lo,
  input  logic signed [H-1:0]  b_hi,
  input  logic        [H-1:0]  b_lo,
  output logic                 pp_valid,
  output logic signed [PW-1:0] pp_hh,
  output logic signed [XW-1:0] pp_mid,
  output logic        [PW-1:0] pp_ll
);
  logic signed [PW-1:0] hh_w;
  logic        [PW-1:0] ll_w;
  logic signed [XW-1:0] mid_w;
  logic signed [H:0]    a_lo_s, b_lo_s;

  assign a_lo_s = $signed({1'b0, a_lo});
  assign b_lo_s = $signed({1'b0, b_lo});

  assign hh_w = PW'(a_hi) * PW'(b_hi);
  assign ll_w = PW'(a_lo) * PW'(b_lo);

  generate
    if (ARCH == ARCH_FOUR) begin : g_four
      logic signed [CW-1:0] hl_w, lh_w;
      assign hl_w  = CW'(a_hi) * CW'(b_lo_s);
      assign lh_w  = CW'(a_lo_s) * CW'(b_hi);
      assign mid_w = XW'(hl_w) + XW'(lh_w);
    end else begin : g_three
      logic signed [SW-1:0] sa_w, sb_w;
      assign sa_w  = SW'(a_hi) + SW'(a_lo_s);
      assign sb_w  = SW'(b_hi) + SW'(b_lo_s);
      assign mid_w = XW'(sa_w) * XW'(sb_w);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_valid <= 1'b0;
      pp_hh    <= '0;
      pp_mid   <= '0;
      pp_ll    <= '0;
    end else begin
      pp_valid <= in_valid;
      if (in_valid) begin
        pp_hh  <= hh_w;
        pp_mid <= mid_w;
        pp_ll  <= ll_w;
      end
    end
  end

  AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pp_valid); // R2
  AST_STAGE1_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !pp_valid); // R3
endmodule

// File: rtl/smul_recombine.sv
module smul_recombine
  import wide_smul_pkg::*;
#(
  parameter int         W    = 36,
  parameter smul_arch_e ARCH = ARCH_THREE,
  localparam int H  = W / 2,
  localparam int PW = 2 * H,
  localparam int XW = 2 * H + 4,
  localparam int RW = 2 * W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pp_valid,
  input  logic signed [PW-1:0] pp_hh,
  input  logic signed [XW-1:0] pp_mid,
  input  logic        [PW-1:0] pp_ll,
  output logic                 out_valid,
  output logic signed [RW-1:0] prod_out
);
  logic signed [RW-1:0] hh_x, mid_x, ll_x, cross_x, sum_w;

  assign hh_x  = RW'(pp_hh);
  assign mid_x = RW'(pp_mid);
  assign ll_x  = $signed({{(RW-PW){1'b0}}, pp_ll});

  generate
    if (ARCH == ARCH_FOUR) begin : g_four
      assign cross_x = mid_x;
    end else begin : g_three
      // Karatsuba middle term: (aH+aL)(bH+bL) - aH*bH - aL*bL
      assign cross_x = mid_x - hh_x - ll_x;
    end
  endgenerate

  assign sum_w = (hh_x <<< (2 * H)) + (cross_x <<< H) + ll_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_out  <= '0;
    end else begin
      out_valid <= pp_valid;
      if (pp_valid) prod_out <= sum_w;
    end
  end

  AST_STAGE2_VALID: assert property (@(posedge clk) disable iff (rst)
    pp_valid |=> out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pp_valid |=> $stable(prod_out)); // R8
endmodule

// File: rtl/wide_smul.sv
module wide_smul
  import wide_smul_pkg::*;
#(
  parameter int         W    = 36,
  parameter smul_arch_e ARCH = ARCH_THREE,
  localparam int H  = W / 2,
  localparam int PW = 2 * H,
  localparam int XW = 2 * H + 4,
  localparam int RW = 2 * W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  a_in,
  input  logic signed [W-1:0]  b_in,
  output logic                 out_valid,
  output logic signed [RW-1:0] prod_out
);
  logic signed [H-1:0]  a_hi, b_hi;
  logic        [H-1:0]  a_lo, b_lo;
  logic                 pp_valid;
  logic signed [PW-1:0] pp_hh;
  logic signed [XW-1:0] pp_mid;
  logic        [PW-1:0] pp_ll;

  smul_half_split #(.W(W)) u_split_a (.op(a_in), .hi(a_hi), .lo(a_lo));
  smul_half_split #(.W(W)) u_split_b (.op(b_in), .hi(b_hi), .lo(b_lo));

  smul_partial_stage #(.W(W), .ARCH(ARCH)) u_pp (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .pp_valid(pp_valid), .pp_hh(pp_hh), .pp_mid(pp_mid), .pp_ll(pp_ll)
  );

  smul_recombine #(.W(W), .ARCH(ARCH)) u_sum (
    .clk(clk), .rst(rst), .pp_valid(pp_valid),
    .pp_hh(pp_hh), .pp_mid(pp_mid), .pp_ll(pp_ll),
    .out_valid(out_valid), .prod_out(prod_out)
  );

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (prod_out == RW'($past(a_in, 2)) * RW'($past(b_in, 2)))); // R1
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pp_valid |=> !out_valid); // R3
endmodule

// File: tb/wide_smul_tb.sv
module wide_smul_tb;
  import wide_smul_pkg::*;
  localparam int W  = 36;
  localparam int RW = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] a_in = '0, b_in = '0;
  logic out_valid, out_valid_f;
  logic signed [RW-1:0] prod_out, prod_out_f;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wide_smul #(.W(W), .ARCH(ARCH_THREE)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .prod_out(prod_out));

  wide_smul #(.W(W), .ARCH(ARCH_FOUR)) u_dut_four (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid_f), .prod_out(prod_out_f));

  function automatic logic signed [RW-1:0] ref_mul(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [RW-1:0] ax, bx;
    ax = RW'(a);
    bx = RW'(b);
    return ax * bx;
  endfunction

  task automatic chk_bit(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s valid: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic chk_val(string req, logic signed [RW-1:0] got, logic signed [RW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s product: got %0d expected %0d", req, got, exp);
    end
  endtask

  // R10: both architectures must agree on every observed cycle
  task automatic chk_arch();
    chk_bit("R10", out_valid_f, out_valid);
    chk_val("R10", prod_out_f, prod_out);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    a_in = 36'sd5; b_in = 36'sd7;
    repeat (3) @(negedge clk);
    chk_bit("R9", out_valid, 1'b0);
    chk_val("R9", prod_out, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk_bit("R9", out_valid, 1'b0);
    chk_val("R9", prod_out, '0);
    chk_arch();
  endtask

  // One pair, result two edges later, then hold with valid low
  task automatic test_single(string req, logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [RW-1:0] e;
    e = ref_mul(a, b);
    @(negedge clk);
    a_in = a; b_in = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a_in = 36'sd3; b_in = -36'sd9;
    @(negedge clk);
    chk_bit("R2", out_valid, 1'b1);
    chk_val(req, prod_out, e);
    chk_arch();
    @(negedge clk);
    chk_bit("R3", out_valid, 1'b0);
    chk_val("R8", prod_out, e);
    chk_arch();
  endtask

  task automatic test_random(int n);
    for (int i = 0; i < n; i++) begin
      test_single("R1", W'({$urandom(), $urandom()}), W'({$urandom(), $urandom()}));
    end
  endtask

  // Back-to-back stream with a valid pattern containing gaps
  task automatic test_stream(int n, bit gaps);
    logic signed [W-1:0] qa [32];
    logic signed [W-1:0] qb [32];
    bit qv [32];
    logic signed [RW-1:0] last;
    last = prod_out;
    for (int i = 0; i < n; i++) begin
      qa[i] = W'({$urandom(), $urandom()});
      qb[i] = W'({$urandom(), $urandom()});
      qv[i] = gaps ? ((i % 3) != 1) : 1'b1;
    end
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk_bit(gaps ? "R3" : "R4", out_valid, qv[i-2]);
        if (qv[i-2]) last = ref_mul(qa[i-2], qb[i-2]);
        chk_val(gaps ? "R8" : "R4", prod_out, last);
        chk_arch();
      end
      if (i < n) begin
        a_in = qa[i]; b_in = qb[i]; in_valid = qv[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    logic signed [W-1:0] most_neg;
    most_neg = {1'b1, {(W-1){1'b0}}};
    test_reset();
    test_single("R5", most_neg, most_neg);
    chk_val("R5", prod_out, 72'sd1 <<< 70);
    test_single("R6", most_neg, -36'sd1);
    chk_val("R6", prod_out, 72'sd1 <<< 35);
    test_single("R6", -36'sd1, most_neg);
    test_single("R7", '0, most_neg);
    test_single("R7", -36'sd12345, '0);
    test_single("R1", 36'sh7_FFFF_FFFF, 36'sh7_FFFF_FFFF);
    test_single("R1", most_neg, 36'sh7_FFFF_FFFF);
    test_single("R1", 36'sh0_0003_FFFF, -36'sh0_0003_FFFF);
    test_random(40);
    test_stream(24, 1'b0);
    test_stream(24, 1'b1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule